// File: doc/BRIEF.md
# Looping DMA Sample Playback Channel

This block is one playback voice of a sound generator. A sample buffer sits in word-wide memory. Each word holds two signed 8-bit amplitude samples. The channel requests words from that memory over a simple request/acknowledge DMA port. It plays the upper byte of each word and then the lower byte. Each sample it emits is multiplied by a linear volume, which gives a signed 15-bit value.

Samples come out at a fixed rate. A down-counter is reloaded from a period value given in clock cycles. A period that is too short is raised to a floor. When the channel has fetched the number of words given by the buffer length, it goes back to the buffer's start address and raises a one-cycle loop pulse. This lets the surrounding system replace the buffer settings for the next pass.

Mixing several voices and converting to an analog signal are done outside this block.

Top module: `audio_sample_channel`

## Requirements
- R1: After synchronous reset, `dma_req`, `sample_valid`, `loop_irq` and `sample_out` are all zero.
- R2: When `enable` is sampled high while the channel is idle, `dma_req` rises on the next cycle. Its address is `start_addr` with bit 0 forced to zero, so buffers are always word aligned.
- R3: `dma_req` stays high until a cycle in which `dma_ack` is high. `dma_data` is taken in that same cycle.
- R4: Each fetched word gives two samples. Bits 15:8 are played first and bits 7:0 second, both read as two's-complement bytes.
- R5: The first `sample_valid` pulse comes P cycles after the acknowledge of the first word. Later pulses come every P cycles, where P is the effective period.
- R6: A `period` below MIN_PERIOD (default 124) is used as MIN_PERIOD. Otherwise P equals `period`.
- R7: `sample_out` equals the signed byte times the volume as a signed 15-bit value. A `volume` above 64 acts as 64, and volume 0 gives 0. `sample_out` holds its value between pulses.
- R8: The request for the next word is raised in the cycle after the upper byte's pulse, when the lower byte's slot begins.
- R9: Each acknowledge advances the fetch address by 2. After `len_words` acknowledges, the address returns to the start address. A length of 0 acts as 1.
- R10: `loop_irq` is high for exactly one cycle: the cycle after the acknowledge of the buffer's last word.
- R11: If the acknowledge comes in the same cycle as the lower byte's pulse, the word delivered by that acknowledge is the next one played.
- R12: While `enable` is low, the channel drops `dma_req`, emits no `sample_valid` pulses and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the channel; low stops it and returns it to idle |
| start_addr | input | 16 | Byte address of the buffer start (bit 0 ignored) |
| len_words | input | 16 | Buffer length in 16-bit words |
| period | input | 16 | Cycles per sample, raised to MIN_PERIOD if smaller |
| volume | input | 7 | Linear volume 0..64, larger values act as 64 |
| dma_req | output | 1 | Word fetch request |
| dma_addr | output | 16 | Byte address of the requested word |
| dma_ack | input | 1 | Fetch acknowledge, qualifies `dma_data` |
| dma_data | input | 16 | Fetched word, upper byte played first |
| sample_out | output | 15 | Scaled signed sample |
| sample_valid | output | 1 | One-cycle pulse when `sample_out` is updated |
| loop_irq | output | 1 | One-cycle pulse when the buffer wraps |

## Verification
Two events can fall in the same cycle. One is the arrival of a fetched word. The other is the pulse that ends the lower byte's slot and swaps in the next word. The bench provokes this by setting the period to its floor and delaying the acknowledge by exactly one period less one cycle. The acknowledge then lands on the cycle of that swap. A behavioural reference model runs beside the design and compares every output on every cycle. The bench also counts how often the two events coincide and requires both a nonzero count and zero mismatches, so a design that swaps in the stale buffered word is caught.

// File: rtl/ach_pkg.sv
package ach_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_FETCH = 2'd1,
    CH_PLAY  = 2'd2
  } ch_state_t;
endpackage

// File: rtl/ach_timer.sv
module ach_timer #(
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 124
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per_eff;

  assign per_eff = (period < MIN_P) ? MIN_P : period;
  assign expire  = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= per_eff - PER_W'(1);
    end else if (run) begin
      if (cnt == '0) cnt <= per_eff - PER_W'(1);
      else           cnt <= cnt - PER_W'(1);
    end
  end

  AST_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (expire || load) |=> (cnt >= MIN_P - PER_W'(1))); // R6
endmodule

// File: rtl/ach_fetch.sv
module ach_fetch #(
  parameter int AW = 16,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] len_words,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  logic [LW-1:0] left;
  logic [LW-1:0] len_eff;
  logic [AW-1:0] base;

  assign len_eff = (len_words == '0) ? LW'(1) : len_words;
  assign base    = start_addr & ~AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      left <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (load) begin
        addr <= base;
        left <= len_eff;
      end else if (step) begin
        if (left <= LW'(1)) begin
          addr <= base;
          left <= len_eff;
          wrap <= 1'b1;
        end else begin
          addr <= addr + AW'(2);
          left <= left - LW'(1);
        end
      end
    end
  end

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap); // R10
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && !load && left > LW'(1)) |=> (addr == $past(addr) + AW'(2))); // R9
endmodule

// File: rtl/ach_scale.sv
module ach_scale #(
  parameter int SW = 8,
  parameter int VW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [SW-1:0]      sample,
  input  logic [VW-1:0]      volume,
  output logic [SW+VW-1:0]   out,
  output logic               valid
);
  localparam int OW      = SW + VW;
  localparam int VOL_MAX = 1 << (VW - 1);
  localparam int LO_LIM  = -(1 << (SW - 1)) * VOL_MAX;
  localparam int HI_LIM  = ((1 << (SW - 1)) - 1) * VOL_MAX;

  logic [VW-1:0]        vol_eff;
  logic signed [OW:0]   prod;

  assign vol_eff = (volume > VW'(VOL_MAX)) ? VW'(VOL_MAX) : volume;
  assign prod    = (OW+1)'($signed(sample)) * (OW+1)'($signed({1'b0, vol_eff}));

  always_ff @(posedge clk) begin
    if (rst) begin
      out   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= fire;
      if (fire) out <= prod[OW-1:0];
    end
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    ($signed(out) >= LO_LIM) && ($signed(out) <= HI_LIM)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |-> $stable(out)); // R7
endmodule

// File: rtl/audio_sample_channel.sv
module audio_sample_channel #(
  parameter int AW         = 16,
  parameter int LW         = 16,
  parameter int PER_W      = 16,
  parameter int MIN_PERIOD = 124,
  parameter int SW         = 8,
  parameter int VW         = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [AW-1:0]       start_addr,
  input  logic [LW-1:0]       len_words,
  input  logic [PER_W-1:0]    period,
  input  logic [VW-1:0]       volume,
  output logic                dma_req,
  output logic [AW-1:0]       dma_addr,
  input  logic                dma_ack,
  input  logic [2*SW-1:0]     dma_data,
  output logic [SW+VW-1:0]    sample_out,
  output logic                sample_valid,
  output logic                loop_irq
);
  import ach_pkg::*;

  localparam int DW = 2 * SW;
  localparam int GW = $clog2(MIN_PERIOD + 1);

  ch_state_t     st;
  logic [DW-1:0] cur_w;
  logic [DW-1:0] nxt_w;
  logic          byte_lo;
  logic          acc;
  logic          start_go;
  logic          first_ack;
  logic          run;
  logic          expire;
  logic [SW-1:0] samp_sel;

  assign acc       = dma_ack && dma_req && enable;
  assign start_go  = enable && (st == CH_IDLE);
  assign first_ack = acc && (st == CH_FETCH);
  assign run       = enable && (st == CH_PLAY);
  assign samp_sel  = byte_lo ? cur_w[SW-1:0] : cur_w[DW-1:SW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CH_IDLE;
      dma_req <= 1'b0;
      cur_w   <= '0;
      nxt_w   <= '0;
      byte_lo <= 1'b0;
    end else if (!enable) begin
      st      <= CH_IDLE;
      dma_req <= 1'b0;
    end else begin
      case (st)
        CH_IDLE: begin
          st      <= CH_FETCH;
          dma_req <= 1'b1;
        end
        CH_FETCH: begin
          if (acc) begin
            st      <= CH_PLAY;
            cur_w   <= dma_data;
            byte_lo <= 1'b0;
            dma_req <= 1'b0;
          end
        end
        default: begin
          if (acc) begin
            nxt_w   <= dma_data;
            dma_req <= 1'b0;
          end
          if (expire) begin
            if (!byte_lo) begin
              byte_lo <= 1'b1;
              dma_req <= 1'b1;
            end else begin
              byte_lo <= 1'b0;
              cur_w   <= acc ? dma_data : nxt_w;
            end
          end
        end
      endcase
    end
  end

  ach_timer #(.PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .run(run), .load(first_ack),
    .period(period), .expire(expire)
  );

  ach_fetch #(.AW(AW), .LW(LW)) u_fetch (
    .clk(clk), .rst(rst), .load(start_go), .step(acc),
    .start_addr(start_addr), .len_words(len_words),
    .addr(dma_addr), .wrap(loop_irq)
  );

  ach_scale #(.SW(SW), .VW(VW)) u_scale (
    .clk(clk), .rst(rst), .fire(expire), .sample(samp_sel),
    .volume(volume), .out(sample_out), .valid(sample_valid)
  );

  // Checker state: cycles since the last sample pulse, saturating.
  logic [GW-1:0] gap;
  logic          seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sample_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap < GW'(MIN_PERIOD)) begin
      gap <= gap + GW'(1);
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack && enable) |=> dma_req); // R3
  AST_REQ_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    ($rose(dma_req) && st == CH_PLAY) |-> byte_lo); // R8
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && seen) |-> (gap >= GW'(MIN_PERIOD - 1))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sample_valid && !dma_req)); // R12
endmodule

// File: tb/audio_sample_channel_tb.sv
module audio_sample_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MINP       = 124;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [15:0] start_addr;
  logic [15:0] len_words;
  logic [15:0] period;
  logic [6:0]  volume;
  logic        dma_req;
  logic [15:0] dma_addr;
  logic        dma_ack;
  logic [15:0] dma_data;
  logic [14:0] sample_out;
  logic        sample_valid;
  logic        loop_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ack_delay = 3;
  int wait_cnt = 0;
  int last_v = -1;
  int exp_gap = 0;
  int coin = 0;
  logic prev_ack = 1'b0;
  logic started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_sample_channel u_dut (
    .clk(clk), .rst(rst), .enable(enable), .start_addr(start_addr),
    .len_words(len_words), .period(period), .volume(volume),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_ack(dma_ack),
    .dma_data(dma_data), .sample_out(sample_out),
    .sample_valid(sample_valid), .loop_irq(loop_irq)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return {8'(a * 16'd37 + 16'h81), 8'(a * 16'd11 + 16'h5a)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Memory responder: acknowledges ack_delay cycles after seeing a request.
  initial begin
    dma_ack  = 1'b0;
    dma_data = '0;
    forever begin
      @(negedge clk);
      dma_ack = 1'b0;
      if (dma_req) begin
        if (wait_cnt == ack_delay) begin
          dma_ack  = 1'b1;
          dma_data = mem_word(dma_addr);
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  // Behavioural reference model, updated on each rising edge.
  int mst, mcnt, mptr, mleft, mout, mlo;
  bit mreq, mirq, mval;
  logic [15:0] mcur, mnxt;

  always @(posedge clk) begin
    int peff, leff, veff, ncnt, s;
    bit acc, fire;
    cyc++;
    started = 1'b1;
    if (rst) begin
      mst = 0; mreq = 0; mcur = '0; mnxt = '0; mlo = 0; mcnt = 0;
      mptr = 0; mleft = 0; mirq = 0; mout = 0; mval = 0;
    end else begin
      peff = (period < MINP) ? MINP : int'(period);
      leff = (len_words == 0) ? 1 : int'(len_words);
      veff = (volume > 64) ? 64 : int'(volume);
      acc  = dma_ack && mreq && enable;
      fire = enable && mst == 2 && mcnt == 0;
      ncnt = mcnt;
      if (enable && mst == 1 && acc) ncnt = peff - 1;
      else if (enable && mst == 2) ncnt = (mcnt == 0) ? peff - 1 : mcnt - 1;
      mirq = 0;
      if (enable && mst == 0) begin
        mptr = int'(start_addr) & 16'hfffe; mleft = leff;
      end else if (acc) begin
        if (mleft <= 1) begin
          mptr = int'(start_addr) & 16'hfffe; mleft = leff; mirq = 1;
        end else begin
          mptr = (mptr + 2) & 16'hffff; mleft--;
        end
      end
      mval = fire;
      if (fire) begin
        s = mlo ? int'($signed(mcur[7:0])) : int'($signed(mcur[15:8]));
        mout = s * veff;
      end
      if (!enable) begin
        mst = 0; mreq = 0;
      end else if (mst == 0) begin
        mst = 1; mreq = 1;
      end else if (mst == 1) begin
        if (acc) begin mst = 2; mcur = dma_data; mlo = 0; mreq = 0; end
      end else begin
        if (acc) begin mnxt = dma_data; mreq = 0; end
        if (fire) begin
          if (mlo == 0) begin mlo = 1; mreq = 1; end
          else begin mlo = 0; mcur = acc ? dma_data : mnxt; end
        end
      end
      mcnt = ncnt;
    end
  end

  // Per-cycle comparison, away from the rising edge.
  always @(negedge clk) begin
    if (started) begin
      check(dma_req == mreq, "R3 R8 dma_req", int'(dma_req), int'(mreq));
      if (dma_req)
        check(int'(dma_addr) == mptr, "R9 dma_addr", int'(dma_addr), mptr);
      check(sample_valid == mval, "R5 sample_valid", int'(sample_valid), int'(mval));
      check(int'($signed(sample_out)) == mout, "R4 R7 sample_out",
            int'($signed(sample_out)), mout);
      check(loop_irq == mirq, "R10 loop_irq", int'(loop_irq), int'(mirq));
      if (sample_valid) begin
        if (last_v >= 0)
          check(cyc - last_v == exp_gap, "R5 R6 pulse spacing", cyc - last_v, exp_gap);
        last_v = cyc;
      end
      if (prev_ack && sample_valid) coin++;
      prev_ack = dma_ack;
    end
  end

  task automatic run_phase(input logic [15:0] sa, input logic [15:0] ln,
                           input logic [15:0] pr, input logic [6:0] vo,
                           input int d, input int n);
    enable = 1'b0;
    @(negedge clk);
    start_addr = sa; len_words = ln; period = pr; volume = vo;
    ack_delay = d;
    exp_gap = (pr < MINP) ? MINP : int'(pr);
    last_v = -1;
    enable = 1'b1;
    @(negedge clk);
    // R2: first request at the word-aligned start address
    check(dma_req == 1'b1, "R2 first request", int'(dma_req), 1);
    check(dma_addr == (sa & 16'hfffe), "R2 start address", int'(dma_addr), int'(sa & 16'hfffe));
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int err0, irq_cnt;
    rst = 1'b1; enable = 1'b0;
    start_addr = '0; len_words = '0; period = '0; volume = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(dma_req == 1'b0, "R1 dma_req", int'(dma_req), 0);
    check(sample_valid == 1'b0, "R1 sample_valid", int'(sample_valid), 0);
    check(loop_irq == 1'b0, "R1 loop_irq", int'(loop_irq), 0);
    check(sample_out == '0, "R1 sample_out", int'(sample_out), 0);

    // R4 R5 R9 R10: odd start address, three-word loop, full volume
    run_phase(16'h0011, 16'd3, 16'd200, 7'd64, 3, 3000);
    // R6 R7 R9: short period raised to floor, volume above 64, length 0
    run_phase(16'h0040, 16'd0, 16'd50, 7'd100, 1, 1500);
    // R11: acknowledge lands on the lower byte's pulse
    err0 = errors; coin = 0;
    run_phase(16'h0100, 16'd2, 16'd124, 7'd33, MINP - 1, 2000);
    check(coin > 0, "R11 coincidence provoked", coin, 1);
    check(errors == err0, "R11 no mismatch under coincidence", errors - err0, 0);
    // R7: volume 0 silences output; R8 timing via model compare
    run_phase(16'h0200, 16'd4, 16'd130, 7'd0, 0, 800);
    // R12: disabled channel stays quiet
    enable = 1'b0;
    irq_cnt = 0;
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sample_valid || dma_req) irq_cnt++;
    end
    check(irq_cnt == 0, "R12 quiet while disabled", irq_cnt, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule